// File: doc/BRIEF.md
# Stub-Pair Extrapolation Match Unit

This block decides whether two trigger stubs, one taken from each of two detector stations, can belong to the same track. Each stub arrives as a 5-bit eta, a 7-bit coarse phi and a 3-bit stub quality. The block forms the signed eta step and the signed phi step from stub A to stub B. It tests the eta step against a loadable acceptance table and the size of the phi step against a fixed angular window. The two results are then joined with a bend-consistency flag and a 2-bit PT class, both produced by neighbouring logic. A loadable quality table turns that 5-bit word into a 2-bit extrapolation quality, where 0 means the pair is rejected.

A second loadable table joins the two stub qualities into a 2-bit combined quality, which is where quality cuts are applied. All three tables share one write port. After reset every table holds a pattern that accepts everything, so each correlation can be opened fully, for example to turn off matching in eta. Every output comes from the same stub pair, and all outputs appear a fixed four clock edges after the edge that captures that pair.

Top module: `stub_pair_match`

## Requirements
- R1: While rst_n is low, every output (eta_out, dphi_mag, dphi_neg, match_q, pair_q) is 0.
- R2: Every output belongs to the stub pair captured four rising edges earlier. eta_out repeats stub A's eta.
- R3: The phi step is d = b_phi - a_phi. dphi_neg is 1 exactly when d < 0. dphi_mag is |d| when |d| <= 63, and 63 otherwise.
- R4: The phi flag is 1 exactly when |d| <= PHI_LIMIT (default 32). A step that does not fit in 6 bits is a non-match.
- R5: The eta flag is the eta table entry addressed by (b_eta - a_eta) mod 64, which is the 6-bit two's complement step.
- R6: match_q is the quality table entry at address {eta flag, phi flag, bend_ok, pt_class}, with the eta flag as bit 4 and pt_class as bits 1:0.
- R7: pair_q is the stub-quality table entry at address {a_qual, b_qual}, with a_qual as bits 5:3.
- R8: After reset, each eta table entry is 1, each quality table entry is 3 and each stub-quality table entry is 3.
- R9: With tbl_we high at a rising edge, tbl_data is written at tbl_addr into the table chosen by tbl_sel (0 = eta table using data bit 0, 1 = quality table using address bits 4:0, 2 = stub-quality table). Pairs captured after that edge use the new entry.
- R10: A cycle with tbl_we low, or with tbl_sel = 3, changes no table entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_eta | input | 5 | Stub A eta |
| a_phi | input | 7 | Stub A coarse phi |
| a_qual | input | 3 | Stub A quality |
| b_eta | input | 5 | Stub B eta |
| b_phi | input | 7 | Stub B coarse phi |
| b_qual | input | 3 | Stub B quality |
| pt_class | input | 2 | External PT class for this pair |
| bend_ok | input | 1 | External bend-consistency flag for this pair |
| tbl_we | input | 1 | Table write strobe |
| tbl_sel | input | 2 | Table select: 0 eta, 1 quality, 2 stub quality, 3 none |
| tbl_addr | input | 6 | Table write address |
| tbl_data | input | 2 | Table write data |
| eta_out | output | 5 | Stub A eta, aligned with the results |
| dphi_mag | output | 6 | Saturated magnitude of the phi step |
| dphi_neg | output | 1 | Sign of the phi step B minus A |
| match_q | output | 2 | Extrapolation quality, 0 = no match |
| pair_q | output | 2 | Combined stub quality |

## Verification
Every result, from eta_out to match_q and pair_q, is due on the fourth rising edge after the edge that captured its pair, even though the match path passes through three register levels and two table reads. The bench drives one pair on each falling edge and puts the expected result into a queue that is four entries deep. On each falling edge it compares the oldest entry with the outputs, so every result is sampled half a cycle after it settles. A table write makes the expectations still in the queue don't-care, because those pairs may read the tables on either side of the write. Pairs presented after the write are checked against the updated model tables.

// File: rtl/smu_pkg.sv
package smu_pkg;
  localparam int ETA_W   = 5;
  localparam int PHI_W   = 7;
  localparam int SQ_W    = 3;
  localparam int PT_W    = 2;
  localparam int Q_W     = 2;
  localparam int DETA_W  = ETA_W + 1;
  localparam int DPHI_W  = 6;
  localparam int QADDR_W = 3 + PT_W;
  localparam int SADDR_W = 2 * SQ_W;
  localparam int TADDR_W = 6;

  typedef struct packed {
    logic [ETA_W-1:0] eta;
    logic [PHI_W-1:0] phi;
    logic [SQ_W-1:0]  qual;
  } stub_t;

  typedef enum logic [1:0] {
    TBL_ETA  = 2'd0,
    TBL_QUAL = 2'd1,
    TBL_STUB = 2'd2,
    TBL_NONE = 2'd3
  } tbl_sel_e;

  // eta step B - A, two's complement, one bit wider than eta
  function automatic logic [DETA_W-1:0] eta_step(input logic [ETA_W-1:0] a,
                                                 input logic [ETA_W-1:0] b);
    return {1'b0, b} - {1'b0, a};
  endfunction

  // phi step B - A, two's complement, one bit wider than phi
  function automatic logic [PHI_W:0] phi_step(input logic [PHI_W-1:0] a,
                                              input logic [PHI_W-1:0] b);
    return {1'b0, b} - {1'b0, a};
  endfunction

  // magnitude of a phi step (never the most negative code)
  function automatic logic [PHI_W-1:0] step_abs(input logic [PHI_W:0] d);
    return d[PHI_W] ? (~d[PHI_W-1:0] + 1'b1) : d[PHI_W-1:0];
  endfunction
endpackage

// File: rtl/smu_lut.sv
module smu_lut #(
  parameter int AW = 6,
  parameter int DW = 2,
  parameter logic [DW-1:0] INIT = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // R8: accept-all contents at reset; R9: write strobe; registered read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= INIT;
      rdata <= '0;
    end else begin
      if (we) mem[waddr] <= wdata;
      rdata <= mem[raddr];
    end
  end
endmodule

// File: rtl/smu_pipe.sv
module smu_pipe #(
  parameter int W = 1,
  parameter int D = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (D == 0) begin : g_wire
      assign q = d;
    end else begin : g_regs
      logic [W-1:0] st [D];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < D; i++) st[i] <= '0;
        end else begin
          st[0] <= d;
          for (int i = 1; i < D; i++) st[i] <= st[i-1];
        end
      end
      assign q = st[D-1];
    end
  endgenerate
endmodule

// File: rtl/smu_diff.sv
module smu_diff
  import smu_pkg::*;
#(
  parameter int PHI_LIMIT = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  stub_t             sa,
  input  stub_t             sb,
  output logic [DETA_W-1:0] deta,
  output logic [DPHI_W-1:0] dphi_mag,
  output logic              dphi_neg,
  output logic              phi_ok
);
  localparam logic [DPHI_W-1:0] LIM = DPHI_W'(PHI_LIMIT);

  logic [PHI_W:0]   dp;
  logic [PHI_W-1:0] mag_full;
  logic             ovf;

  always_comb begin
    dp       = phi_step(sa.phi, sb.phi);
    mag_full = step_abs(dp);
    ovf      = |mag_full[PHI_W-1:DPHI_W];
  end

  // R3, R4, R5: stage 2 registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      deta     <= '0;
      dphi_mag <= '0;
      dphi_neg <= 1'b0;
      phi_ok   <= 1'b0;
    end else begin
      deta     <= eta_step(sa.eta, sb.eta);
      dphi_mag <= ovf ? '1 : mag_full[DPHI_W-1:0];
      dphi_neg <= dp[PHI_W];
      phi_ok   <= !ovf && (mag_full[DPHI_W-1:0] <= LIM);
    end
  end
endmodule

// File: rtl/stub_pair_match.sv
module stub_pair_match
  import smu_pkg::*;
#(
  parameter int PHI_LIMIT = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ETA_W-1:0]   a_eta,
  input  logic [PHI_W-1:0]   a_phi,
  input  logic [SQ_W-1:0]    a_qual,
  input  logic [ETA_W-1:0]   b_eta,
  input  logic [PHI_W-1:0]   b_phi,
  input  logic [SQ_W-1:0]    b_qual,
  input  logic [PT_W-1:0]    pt_class,
  input  logic               bend_ok,
  input  logic               tbl_we,
  input  logic [1:0]         tbl_sel,
  input  logic [TADDR_W-1:0] tbl_addr,
  input  logic [Q_W-1:0]     tbl_data,
  output logic [ETA_W-1:0]   eta_out,
  output logic [DPHI_W-1:0]  dphi_mag,
  output logic               dphi_neg,
  output logic [Q_W-1:0]     match_q,
  output logic [Q_W-1:0]     pair_q
);
  // stage 1: input capture
  stub_t           s1_a, s1_b;
  logic [PT_W-1:0] s1_pt;
  logic            s1_bend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_a    <= '0;
      s1_b    <= '0;
      s1_pt   <= '0;
      s1_bend <= 1'b0;
    end else begin
      s1_a    <= '{eta: a_eta, phi: a_phi, qual: a_qual};
      s1_b    <= '{eta: b_eta, phi: b_phi, qual: b_qual};
      s1_pt   <= pt_class;
      s1_bend <= bend_ok;
    end
  end

  // table write decode (R9, R10)
  tbl_sel_e sel;
  logic     we_eta, we_qual, we_stub;
  assign sel     = tbl_sel_e'(tbl_sel);
  assign we_eta  = tbl_we && (sel == TBL_ETA);
  assign we_qual = tbl_we && (sel == TBL_QUAL);
  assign we_stub = tbl_we && (sel == TBL_STUB);

  // stage 2: differences
  logic [DETA_W-1:0] s2_deta;
  logic [DPHI_W-1:0] s2_mag;
  logic              s2_neg, s2_phi_ok;

  smu_diff #(.PHI_LIMIT(PHI_LIMIT)) u_diff (
    .clk(clk), .rst_n(rst_n), .sa(s1_a), .sb(s1_b),
    .deta(s2_deta), .dphi_mag(s2_mag), .dphi_neg(s2_neg), .phi_ok(s2_phi_ok)
  );

  // stage 3: match flags, all from the same pair
  logic            eta_hit;
  logic            s3_phi_ok;
  logic [PT_W-1:0] s3_pt;
  logic            s3_bend;

  smu_lut #(.AW(DETA_W), .DW(1), .INIT(1'b1)) u_eta_tbl (
    .clk(clk), .rst_n(rst_n), .we(we_eta), .waddr(tbl_addr[DETA_W-1:0]),
    .wdata(tbl_data[0]), .raddr(s2_deta), .rdata(eta_hit)
  );

  smu_pipe #(.W(1), .D(1)) u_phi_dly (
    .clk(clk), .rst_n(rst_n), .d(s2_phi_ok), .q(s3_phi_ok)
  );

  smu_pipe #(.W(PT_W + 1), .D(2)) u_ext_dly (
    .clk(clk), .rst_n(rst_n), .d({s1_bend, s1_pt}), .q({s3_bend, s3_pt})
  );

  // stage 4: quality (R6)
  logic [QADDR_W-1:0] qaddr;
  assign qaddr = {eta_hit, s3_phi_ok, s3_bend, s3_pt};

  smu_lut #(.AW(QADDR_W), .DW(Q_W), .INIT('1)) u_q_tbl (
    .clk(clk), .rst_n(rst_n), .we(we_qual), .waddr(tbl_addr[QADDR_W-1:0]),
    .wdata(tbl_data), .raddr(qaddr), .rdata(match_q)
  );

  // stub quality combination (R7), read at stage 2 then aligned
  logic [Q_W-1:0] s2_pair;

  smu_lut #(.AW(SADDR_W), .DW(Q_W), .INIT('1)) u_s_tbl (
    .clk(clk), .rst_n(rst_n), .we(we_stub), .waddr(tbl_addr[SADDR_W-1:0]),
    .wdata(tbl_data), .raddr({s1_a.qual, s1_b.qual}), .rdata(s2_pair)
  );

  smu_pipe #(.W(Q_W), .D(2)) u_pair_dly (
    .clk(clk), .rst_n(rst_n), .d(s2_pair), .q(pair_q)
  );

  // R2: eta pass-through and phi step aligned with the quality
  smu_pipe #(.W(ETA_W), .D(3)) u_eta_dly (
    .clk(clk), .rst_n(rst_n), .d(s1_a.eta), .q(eta_out)
  );

  smu_pipe #(.W(DPHI_W + 1), .D(2)) u_dphi_dly (
    .clk(clk), .rst_n(rst_n), .d({s2_mag, s2_neg}), .q({dphi_mag, dphi_neg})
  );
endmodule

// File: rtl/smu_check.sv
module smu_check #(
  parameter int PHI_LIMIT = 32
) (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] a_eta,
  input logic [4:0] eta_out,
  input logic [5:0] dphi_mag,
  input logic       dphi_neg,
  input logic [1:0] match_q,
  input logic [1:0] pair_q,
  input logic       tbl_we,
  input logic [1:0] tbl_sel,
  input logic       s3_phi_ok
);
  localparam logic [5:0] LIM = 6'(PHI_LIMIT);

  logic [2:0] age;
  logic       warm, wrote;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age   <= '0;
      wrote <= 1'b0;
    end else begin
      if (age != 3'd7) age <= age + 3'd1;
      if (tbl_we && tbl_sel != 2'd3) wrote <= 1'b1;
    end
  end
  assign warm = (age >= 3'd4);

  assert_eta_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> eta_out == $past(a_eta, 4));

  assert_sign_mag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dphi_neg |-> dphi_mag != 6'd0);

  assert_phi_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    s3_phi_ok |=> dphi_mag <= LIM);

  assert_accept_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && !wrote) |-> (match_q == 2'd3 && pair_q == 2'd3));
endmodule

bind stub_pair_match smu_check #(.PHI_LIMIT(PHI_LIMIT)) u_smu_check (
  .clk(clk), .rst_n(rst_n), .a_eta(a_eta), .eta_out(eta_out),
  .dphi_mag(dphi_mag), .dphi_neg(dphi_neg), .match_q(match_q), .pair_q(pair_q),
  .tbl_we(tbl_we), .tbl_sel(tbl_sel), .s3_phi_ok(s3_phi_ok)
);

// File: tb/test_stub_pair_match.sv
`timescale 1ns/1ps
module test_stub_pair_match;
  localparam int LIMIT = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] a_eta = '0, b_eta = '0;
  logic [6:0] a_phi = '0, b_phi = '0;
  logic [2:0] a_qual = '0, b_qual = '0;
  logic [1:0] pt_class = '0;
  logic       bend_ok = 1'b0;
  logic       tbl_we = 1'b0;
  logic [1:0] tbl_sel = 2'd3;
  logic [5:0] tbl_addr = '0;
  logic [1:0] tbl_data = '0;
  logic [4:0] eta_out;
  logic [5:0] dphi_mag;
  logic       dphi_neg;
  logic [1:0] match_q, pair_q;

  int checks = 0;
  int errors = 0;
  int eta_t [64];
  int q_t [32];
  int s_t [64];
  logic [31:0] expq[$];
  string tagq[$];
  string cur_tag = "R8";

  always #2 clk = ~clk;

  stub_pair_match #(.PHI_LIMIT(LIMIT)) i_stub_pair_match (
    .clk(clk), .rst_n(rst_n),
    .a_eta(a_eta), .a_phi(a_phi), .a_qual(a_qual),
    .b_eta(b_eta), .b_phi(b_phi), .b_qual(b_qual),
    .pt_class(pt_class), .bend_ok(bend_ok),
    .tbl_we(tbl_we), .tbl_sel(tbl_sel), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
    .eta_out(eta_out), .dphi_mag(dphi_mag), .dphi_neg(dphi_neg),
    .match_q(match_q), .pair_q(pair_q)
  );

  // behavioural reference: bit31 valid, 17:16 match, 15:14 pair, 13:9 eta, 8:3 mag, 2 sign
  function automatic logic [31:0] model(input logic [4:0] ae, input logic [4:0] be,
                                        input logic [6:0] ap, input logic [6:0] bp,
                                        input logic [2:0] aq, input logic [2:0] bq,
                                        input logic [1:0] pt, input logic bo);
    int de, dp, m, em, pm, q, s;
    logic [31:0] r;
    de = int'(be) - int'(ae);
    em = eta_t[(de + 64) % 64];
    dp = int'(bp) - int'(ap);
    m  = (dp < 0) ? -dp : dp;
    pm = (m <= LIMIT) ? 1 : 0;
    q  = q_t[em * 16 + pm * 8 + int'(bo) * 4 + int'(pt)];
    s  = s_t[int'(aq) * 8 + int'(bq)];
    r = '0;
    r[31]    = 1'b1;
    r[17:16] = 2'(q);
    r[15:14] = 2'(s);
    r[13:9]  = ae;
    r[8:3]   = 6'((m > 63) ? 63 : m);
    r[2]     = (dp < 0);
    return r;
  endfunction

  task automatic compare(input logic [31:0] e, input string t);
    checks++;
    if (eta_out !== e[13:9]) begin
      errors++;
      $display("FAIL R2 eta_out actual %0d expected %0d", eta_out, e[13:9]);
    end
    checks++;
    if ({dphi_mag, dphi_neg} !== e[8:2]) begin
      errors++;
      $display("FAIL R3 dphi mag/neg actual %0d/%0d expected %0d/%0d",
               dphi_mag, dphi_neg, e[8:3], e[2]);
    end
    checks++;
    if (match_q !== e[17:16]) begin
      errors++;
      $display("FAIL %s match_q actual %0d expected %0d", t, match_q, e[17:16]);
    end
    checks++;
    if (pair_q !== e[15:14]) begin
      errors++;
      $display("FAIL R7 pair_q actual %0d expected %0d", pair_q, e[15:14]);
    end
  endtask

  task automatic cycle(input logic [4:0] ae, input logic [4:0] be,
                       input logic [6:0] ap, input logic [6:0] bp,
                       input logic [2:0] aq, input logic [2:0] bq,
                       input logic [1:0] pt, input logic bo,
                       input logic we, input logic [1:0] sel,
                       input logic [5:0] ad, input logic [1:0] dt);
    logic [31:0] e;
    string t;
    @(negedge clk);
    if (expq.size() == 4) begin
      e = expq.pop_front();
      t = tagq.pop_front();
      if (e[31]) compare(e, t);
    end
    a_eta = ae; b_eta = be; a_phi = ap; b_phi = bp;
    a_qual = aq; b_qual = bq; pt_class = pt; bend_ok = bo;
    tbl_we = we; tbl_sel = sel; tbl_addr = ad; tbl_data = dt;
    if (we) begin
      // pairs in flight may read either side of the write
      foreach (expq[i]) expq[i][31] = 1'b0;
      if (sel == 2'd0) eta_t[ad] = int'(dt[0]);
      else if (sel == 2'd1) q_t[ad[4:0]] = int'(dt);
      else if (sel == 2'd2) s_t[ad] = int'(dt);
    end
    e = model(ae, be, ap, bp, aq, bq, pt, bo);
    if (we) e[31] = 1'b0;
    expq.push_back(e);
    tagq.push_back(cur_tag);
  endtask

  task automatic rand_cycles(input int n, input bit near_eta);
    for (int i = 0; i < n; i++) begin
      logic [4:0] x, y;
      x = 5'($urandom);
      y = near_eta ? 5'(int'(x) + int'($urandom % 7) - 3) : 5'($urandom);
      cycle(x, y, 7'($urandom), 7'($urandom), 3'($urandom), 3'($urandom),
            2'($urandom), 1'($urandom), 1'b0, 2'($urandom), 6'($urandom), 2'($urandom));
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin eta_t[i] = 1; s_t[i] = 3; end
    for (int i = 0; i < 32; i++) q_t[i] = 3;

    // R1: reset state
    repeat (3) @(negedge clk);
    checks++;
    if ({eta_out, dphi_mag, dphi_neg, match_q, pair_q} !== '0) begin
      errors++;
      $display("FAIL R1 outputs in reset actual %0h expected 0",
               {eta_out, dphi_mag, dphi_neg, match_q, pair_q});
    end
    rst_n = 1'b1;
    expq.push_back(model('0, '0, '0, '0, '0, '0, '0, 1'b0));
    tagq.push_back("R1");

    // R8: accept-all tables after reset
    cur_tag = "R8";
    rand_cycles(200, 1'b0);

    // R9: load all three tables
    cur_tag = "R9";
    for (int i = 0; i < 64; i++)
      cycle('0, '0, '0, '0, '0, '0, '0, 1'b0, 1'b1, 2'd0, 6'(i),
            (i <= 2 || i >= 62) ? 2'd1 : 2'd0);
    for (int i = 0; i < 32; i++)
      cycle('0, '0, '0, '0, '0, '0, '0, 1'b0, 1'b1, 2'd1, 6'(i), 2'((i * 5 + (i >> 3)) % 4));
    for (int i = 0; i < 64; i++)
      cycle('0, '0, '0, '0, '0, '0, '0, 1'b0, 1'b1, 2'd2, 6'(i), 2'((i * 3 + (i >> 4)) % 4));
    rand_cycles(60, 1'b1);

    // R4: phi window edges, sign and overflow (R3)
    cur_tag = "R4";
    begin
      int pa [10] = '{10, 10, 42, 43, 0, 0, 100, 0, 5, 64};
      int pb [10] = '{42, 43, 10, 10, 63, 64, 0, 127, 5, 0};
      for (int k = 0; k < 10; k++)
        cycle(5'd9, 5'd9, 7'(pa[k]), 7'(pb[k]), 3'(k), 3'(k + 1),
              2'(k), 1'(k), 1'b0, 2'd3, '0, '0);
    end

    // R5: eta step addressing, including wrap of the 5-bit values
    cur_tag = "R5";
    begin
      int ea [8] = '{0, 31, 3, 5, 3, 10, 10, 17};
      int eb [8] = '{31, 0, 5, 3, 6, 8, 7, 17};
      for (int k = 0; k < 8; k++)
        cycle(5'(ea[k]), 5'(eb[k]), 7'd20, 7'd25, 3'd2, 3'd5, 2'd1, 1'b1,
              1'b0, 2'd3, '0, '0);
    end
    rand_cycles(300, 1'b1);

    // R6: every quality address
    cur_tag = "R6";
    for (int k = 0; k < 32; k++) begin
      logic [4:0] kk;
      kk = 5'(k);
      cycle(5'd7, kk[4] ? 5'd8 : 5'd20, 7'd50, kk[3] ? 7'd82 : 7'd83,
            3'($urandom), 3'($urandom), kk[1:0], kk[2], 1'b0, 2'd3, '0, '0);
    end

    // R7: every stub-quality pair
    cur_tag = "R7";
    for (int k = 0; k < 64; k++)
      cycle(5'd4, 5'd4, 7'd1, 7'd2, 3'(k >> 3), 3'(k), 2'd2, 1'b1, 1'b0, 2'd3, '0, '0);

    // R10: writes with select 3, and non-strobed cycles, leave tables alone
    cur_tag = "R10";
    for (int i = 0; i < 64; i++)
      cycle('0, '0, '0, '0, '0, '0, '0, 1'b0, 1'b1, 2'd3, 6'(i), 2'd0);
    rand_cycles(150, 1'b1);

    cur_tag = "R2";
    repeat (5) cycle('0, '0, '0, '0, '0, '0, '0, 1'b0, 1'b0, 2'd3, '0, '0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog expired actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule